// File: doc/BRIEF.md
# MDIO Management Master

This block carries out clause-22 management transactions towards an external PHY over a two-wire serial management bus. One wire is the MDC clock output. The other is the bidirectional MDIO line, which this block splits into an output value, an output enable and an input. Software drives the block through two registers. One holds the command: PHY address, register number, a direction flag, a start/busy flag, a preamble-skip flag and a 4-bit clock divider. The other holds the 16-bit data.

For a write, software first places the data in the data register. It then writes the command word with the start bit set. The block shifts out preamble, start-of-frame, opcode, PHY address, register number, turnaround and data, most significant bit first. For a read, the block releases the line after the register number and samples 16 bits from the PHY. It stores them in the data register at the moment busy clears. Software polls the busy bit (bit 17 of the command readback) to learn when the transaction is over.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, cmd_rdata reads 0 and data_rdata reads 0.
- R2: While idle, a command write with bit 17 set starts a frame, and cmd_rdata bit 17 reads 1 from the next cycle until the frame ends. A command write with bit 17 clear starts no frame, but it still stores the other fields, which cmd_rdata returns.
- R3: During a frame, mdc has a period of 2×(D+1) clock cycles, where D is command bits 23:20. Each period starts with D+1 cycles low followed by D+1 cycles high. mdc is low whenever the block is idle.
- R4: Frame bits go out most significant first, in this order: 32 ones of preamble, start 01, opcode, PHY address (command bits 12:8), register number (command bits 4:0), turnaround, then 16 data bits. The first bit is driven from the cycle after the command is accepted, and every following bit is driven from the falling edge of mdc.
- R5: On a read, mdio_oe is 0 during the 2 turnaround bits and the 16 data bits, and is 1 for all earlier bits.
- R6: On a read, each data bit is sampled from mdio_i at the rising edge of mdc, first received bit in bit 15. The 16-bit result appears on data_rdata in the same cycle that busy clears.
- R7: When command bit 18 is set, the preamble is left out and the frame is 32 bits long.
- R8: Busy stays set for exactly (bits in frame)×2×(D+1) cycles. mdio_oe is 0 whenever the block is idle.
- R9: A command write that arrives while busy is set has no effect. The running frame and the stored command fields are unchanged.
- R10: Command bit 16 set selects a write, with opcode 01, turnaround driven as 10, data taken from the data register, and mdio_oe held at 1 through the whole frame. Bit 16 clear selects a read, with opcode 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 32 | Command word to write |
| data_wr | input | 1 | Write strobe for the data register |
| data_wdata | input | 16 | Data value to write |
| cmd_rdata | output | 32 | Command readback with live busy bit 17 |
| data_rdata | output | 16 | Data register contents (write data or captured read data) |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | Value driven on the MDIO line |
| mdio_oe | output | 1 | Output enable for the MDIO line |
| mdio_i | input | 1 | Value read from the MDIO line |

## Verification
Every result of an accepted command becomes visible one clock after the accepting edge: busy, mdc low and the first frame bit. From then on, mdc changes every D+1 cycles and the driven bit moves on every 2×(D+1) cycles. Busy clears and read data lands together exactly N×2×(D+1) cycles after acceptance. The bench keeps a cycle counter from the accepting edge and derives the expected mdc level, enable and bit for every cycle from that counter. It compares them against the outputs on the falling clock edge, half a cycle after the registers update. The same counter decides when the bench's PHY model presents each read bit, so every bit is stable across the rising mdc edge that samples it. Busy duration is counted separately and compared against the closed-form length.

// File: rtl/mdio_mgmt_pkg.sv
package mdio_mgmt_pkg;
   // command word layout (software decodes these positions)
   localparam int CMD_REG_LSB   = 0;
   localparam int CMD_PHY_LSB   = 8;
   localparam int CMD_WR_BIT    = 16;
   localparam int CMD_GO_BIT    = 17;
   localparam int CMD_NOPRE_BIT = 18;
   localparam int CMD_DIV_LSB   = 20;
   localparam int CMD_W         = 32;

   // clause-22 frame codes
   localparam logic [1:0] SOF_CODE   = 2'b01;
   localparam logic [1:0] OP_WRITE   = 2'b01;
   localparam logic [1:0] OP_READ    = 2'b10;
   localparam logic [1:0] TA_DRIVEN  = 2'b10;
endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int DIV_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic             mdc_o,
   output logic             rise_o,
   output logic             fall_o
);
   logic [DIV_W-1:0] cnt_q;
   logic             mdc_q;
   logic             wrap;

   assign wrap   = run_i && (cnt_q == div_i);
   assign rise_o = wrap && !mdc_q;
   assign fall_o = wrap &&  mdc_q;
   assign mdc_o  = mdc_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (!run_i) begin
         cnt_q <= '0;
         mdc_q <= 1'b0;
      end else if (wrap) begin
         cnt_q <= '0;
         mdc_q <= ~mdc_q;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // R3: between divider wraps the clock level holds
   assert_half_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !wrap) |=> $stable(mdc_o));
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq #(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 5,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              wr_i,
   input  logic              nopre_i,
   input  logic [ADDR_W-1:0] phy_i,
   input  logic [ADDR_W-1:0] reg_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              rise_i,
   input  logic              fall_i,
   input  logic              mdio_i,
   output logic              active_o,
   output logic              mdio_o,
   output logic              mdio_oe_o,
   output logic              done_rd_o,
   output logic [DATA_W-1:0] rdata_o
);
   import mdio_mgmt_pkg::*;

   localparam int BODY_W  = 6 + 2*ADDR_W + DATA_W;
   localparam int FRAME_W = PRE_LEN + BODY_W;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam logic [CNT_W-1:0] LEN_FULL = CNT_W'(FRAME_W);
   localparam logic [CNT_W-1:0] LEN_BODY = CNT_W'(BODY_W);
   localparam logic [CNT_W-1:0] TAIL_RX  = CNT_W'(DATA_W + 2);
   localparam logic [CNT_W-1:0] DATA_RX  = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   logic [BODY_W-1:0]  body;
   logic [FRAME_W-1:0] frame_full;
   logic [FRAME_W-1:0] shreg_q;
   logic [CNT_W-1:0]   left_q;
   logic [DATA_W-1:0]  cap_q;
   logic               active_q;
   logic               rd_q;
   logic               last_bit;

   assign body = {SOF_CODE, (wr_i ? OP_WRITE : OP_READ), phy_i, reg_i, TA_DRIVEN, wdata_i};

   generate
      if (PRE_LEN > 0) begin : g_with_pre
         assign frame_full = {{PRE_LEN{1'b1}}, body};
      end else begin : g_no_pre
         assign frame_full = body;
      end
   endgenerate

   assign last_bit  = (left_q == ONE);
   assign active_o  = active_q;
   assign mdio_o    = shreg_q[FRAME_W-1];
   assign mdio_oe_o = active_q && !(rd_q && (left_q <= TAIL_RX));
   assign done_rd_o = active_q && fall_i && last_bit && rd_q;
   assign rdata_o   = cap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg_q  <= '0;
         left_q   <= '0;
         cap_q    <= '0;
         active_q <= 1'b0;
         rd_q     <= 1'b0;
      end else if (start_i && !active_q) begin
         shreg_q  <= nopre_i ? (frame_full << PRE_LEN) : frame_full;
         left_q   <= nopre_i ? LEN_BODY : LEN_FULL;
         cap_q    <= '0;
         active_q <= 1'b1;
         rd_q     <= !wr_i;
      end else if (active_q) begin
         if (rise_i && rd_q && (left_q <= DATA_RX))
            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
         if (fall_i) begin
            if (last_bit) begin
               active_q <= 1'b0;
            end else begin
               shreg_q <= shreg_q << 1;
               left_q  <= left_q - ONE;
            end
         end
      end
   end

   // R4: the driven bit only moves on a falling clock tick
   assert_shift_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_q && !fall_i) |=> $stable(mdio_o));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
   parameter int DATA_W  = 16,
   parameter int ADDR_W  = 5,
   parameter int DIV_W   = 4,
   parameter int PRE_LEN = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [31:0]       cmd_wdata,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] data_wdata,
   output logic [31:0]       cmd_rdata,
   output logic [DATA_W-1:0] data_rdata,
   output logic              mdc,
   output logic              mdio_o,
   output logic              mdio_oe,
   input  logic              mdio_i
);
   import mdio_mgmt_pkg::*;

   initial begin
      chk_addr_w:  assert (ADDR_W == 5 && ADDR_W <= CMD_WR_BIT - CMD_PHY_LSB);
      chk_div_w:   assert (CMD_DIV_LSB + DIV_W <= CMD_W);
      chk_data_w:  assert (DATA_W >= 2);
      chk_pre_len: assert (PRE_LEN <= 32);
   end

   logic [ADDR_W-1:0] phy_q, reg_q;
   logic [DIV_W-1:0]  div_q;
   logic              wr_q, nopre_q;
   logic [DATA_W-1:0] data_q;
   logic              busy, accept, go;
   logic              rise_tick, fall_tick, done_rd;
   logic [DATA_W-1:0] cap_data;

   assign accept = cmd_wr && !busy;
   assign go     = accept && cmd_wdata[CMD_GO_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phy_q   <= '0;
         reg_q   <= '0;
         div_q   <= '0;
         wr_q    <= 1'b0;
         nopre_q <= 1'b0;
      end else if (accept) begin
         phy_q   <= cmd_wdata[CMD_PHY_LSB +: ADDR_W];
         reg_q   <= cmd_wdata[CMD_REG_LSB +: ADDR_W];
         div_q   <= cmd_wdata[CMD_DIV_LSB +: DIV_W];
         wr_q    <= cmd_wdata[CMD_WR_BIT];
         nopre_q <= cmd_wdata[CMD_NOPRE_BIT];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       data_q <= '0;
      else if (done_rd) data_q <= cap_data;
      else if (data_wr) data_q <= data_wdata;
   end

   mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (busy),
      .div_i  (div_q),
      .mdc_o  (mdc),
      .rise_o (rise_tick),
      .fall_o (fall_tick)
   );

   mdio_frame_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PRE_LEN(PRE_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (go),
      .wr_i      (cmd_wdata[CMD_WR_BIT]),
      .nopre_i   (cmd_wdata[CMD_NOPRE_BIT]),
      .phy_i     (cmd_wdata[CMD_PHY_LSB +: ADDR_W]),
      .reg_i     (cmd_wdata[CMD_REG_LSB +: ADDR_W]),
      .wdata_i   (data_q),
      .rise_i    (rise_tick),
      .fall_i    (fall_tick),
      .mdio_i    (mdio_i),
      .active_o  (busy),
      .mdio_o    (mdio_o),
      .mdio_oe_o (mdio_oe),
      .done_rd_o (done_rd),
      .rdata_o   (cap_data)
   );

   always_comb begin
      cmd_rdata = '0;
      cmd_rdata[CMD_REG_LSB +: ADDR_W] = reg_q;
      cmd_rdata[CMD_PHY_LSB +: ADDR_W] = phy_q;
      cmd_rdata[CMD_DIV_LSB +: DIV_W]  = div_q;
      cmd_rdata[CMD_WR_BIT]            = wr_q;
      cmd_rdata[CMD_NOPRE_BIT]         = nopre_q;
      cmd_rdata[CMD_GO_BIT]            = busy;
   end
   assign data_rdata = data_q;

   // R2: an accepted start raises busy on the next cycle
   assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && cmd_wdata[CMD_GO_BIT] && !busy) |=> busy);
   // R8: idle means the line is released and the clock is parked low
   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!mdio_oe && !mdc));
   // R8: a frame only ends on a falling clock tick
   assert_end_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> $past(fall_tick));
   // R9: stored command fields hold for the whole frame
   assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable({phy_q, reg_q, div_q, wr_q, nopre_q}));
endmodule

// File: tb/mdio_mgmt_master_tb.sv
`timescale 1ns/1ps
module mdio_mgmt_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [31:0] cmd_wdata = '0;
   logic        data_wr = 1'b0;
   logic [15:0] data_wdata = '0;
   logic [31:0] cmd_rdata;
   logic [15:0] data_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #2.5 clk = ~clk;

   mdio_mgmt_master dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_wdata(cmd_wdata),
      .data_wr(data_wr), .data_wdata(data_wdata), .cmd_rdata(cmd_rdata),
      .data_rdata(data_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   int checks = 0;
   int fails  = 0;
   int wd     = 0;
   bit run_cmp = 1'b0;

   // reference model state
   bit        m_busy, m_was_busy, m_wr, m_nopre;
   bit [4:0]  m_phy, m_reg;
   bit [3:0]  m_divf;
   bit [15:0] m_data;
   bit [15:0] phy_val = 16'h0;
   int        m_k, m_N, m_P, fidx;
   bit        fb[64];
   bit        ob[64];

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic void put(input bit b, input bit o);
      fb[fidx] = b;
      ob[fidx] = o;
      fidx++;
   endfunction

   function automatic void build_frame();
      fidx = 0;
      if (!m_nopre) for (int i = 0; i < 32; i++) put(1'b1, 1'b1);
      put(1'b0, 1'b1); put(1'b1, 1'b1);
      if (m_wr) begin put(1'b0, 1'b1); put(1'b1, 1'b1); end
      else      begin put(1'b1, 1'b1); put(1'b0, 1'b1); end
      for (int i = 4; i >= 0; i--) put(m_phy[i], 1'b1);
      for (int i = 4; i >= 0; i--) put(m_reg[i], 1'b1);
      if (m_wr) begin
         put(1'b1, 1'b1); put(1'b0, 1'b1);
         for (int i = 15; i >= 0; i--) put(m_data[i], 1'b1);
      end else begin
         for (int i = 0; i < 18; i++) put(1'b0, 1'b0);
      end
      m_N = fidx;
      m_P = 2 * (int'(m_divf) + 1);
   endfunction

   function automatic logic [31:0] exp_cmd();
      return {8'h00, m_divf, 1'b0, m_nopre, m_busy, m_wr, 3'b000, m_phy, 3'b000, m_reg};
   endfunction

   // model update on the active edge
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_busy = 0; m_wr = 0; m_nopre = 0; m_phy = 0; m_reg = 0;
         m_divf = 0; m_data = 0; m_k = 0; m_N = 64; m_P = 2;
      end else begin
         m_was_busy = m_busy;
         if (m_busy) begin
            m_k++;
            if (m_k == m_N * m_P) begin
               m_busy = 0;
               if (!m_wr) m_data = phy_val;
            end
         end
         if (data_wr) m_data = data_wdata;
         if (cmd_wr && !m_was_busy) begin
            m_phy   = cmd_wdata[12:8];
            m_reg   = cmd_wdata[4:0];
            m_wr    = cmd_wdata[16];
            m_nopre = cmd_wdata[18];
            m_divf  = cmd_wdata[23:20];
            if (cmd_wdata[17]) begin
               m_busy = 1;
               m_k = 0;
               build_frame();
            end
         end
      end
   end

   // compare on the falling edge, and drive the PHY side of the line
   always @(negedge clk) begin
      int bi;
      bit e_mdc, e_oe;
      bi = m_busy ? (m_k / m_P) : 0;
      e_mdc = m_busy && ((m_k % m_P) >= (int'(m_divf) + 1));
      e_oe  = m_busy && ob[bi];
      if (rst_n && run_cmp) begin
         chk(mdc == e_mdc, "R3", "mdc", mdc, e_mdc);
         chk(mdio_oe == e_oe, "R5 R10", "mdio_oe", mdio_oe, e_oe);
         if (e_oe) chk(mdio_o == fb[bi], "R4", "mdio_o", mdio_o, fb[bi]);
         chk(cmd_rdata == exp_cmd(), "R2 R9", "cmd_rdata", cmd_rdata, exp_cmd());
         chk(data_rdata == m_data, "R6", "data_rdata", data_rdata, m_data);
      end
      if (m_busy && !m_wr && bi >= m_N - 16)
         mdio_i = phy_val[15 - (bi - (m_N - 16))];
      else
         mdio_i = mdio_oe ? mdio_o : 1'b1;
   end

   always @(posedge clk) begin
      wd++;
      if (wd > 60000) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   function automatic logic [31:0] mk(input int div, input bit nopre, input bit go,
                                      input bit wr, input int phy, input int rg);
      logic [31:0] w;
      w = '0;
      w[23:20] = div[3:0];
      w[18] = nopre; w[17] = go; w[16] = wr;
      w[12:8] = phy[4:0];
      w[4:0] = rg[4:0];
      return w;
   endfunction

   task automatic put_data(input logic [15:0] v);
      data_wr = 1'b1; data_wdata = v;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic run_cmd(input logic [31:0] w, input bit inj, input logic [31:0] injw,
                          output int cyc);
      cmd_wr = 1'b1; cmd_wdata = w;
      @(negedge clk);
      cmd_wr = 1'b0;
      cyc = 0;
      while (cmd_rdata[17]) begin
         cyc++;
         if (inj && cyc == 50) begin cmd_wr = 1'b1; cmd_wdata = injw; end
         else cmd_wr = 1'b0;
         @(negedge clk);
      end
      cmd_wr = 1'b0;
   endtask

   initial begin
      int cyc;
      logic [31:0] w;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(mdc == 1'b0, "R1", "mdc in reset", mdc, 0);
      chk(mdio_oe == 1'b0, "R1", "mdio_oe in reset", mdio_oe, 0);
      chk(cmd_rdata == 32'h0, "R1", "cmd_rdata in reset", cmd_rdata, 0);
      chk(data_rdata == 16'h0, "R1", "data_rdata in reset", data_rdata, 0);
      rst_n = 1'b1;
      run_cmp = 1'b1;
      @(negedge clk);

      // R10 write with preamble, divider 1
      put_data(16'hA5C3);
      run_cmd(mk(1, 0, 1, 1, 5'h11, 5'h05), 0, '0, cyc);
      chk(cyc == 64 * 4, "R8", "write busy cycles", cyc, 64 * 4);

      // R6 read, divider 0
      phy_val = 16'h8001;
      run_cmd(mk(0, 0, 1, 0, 5'h1F, 5'h1E), 0, '0, cyc);
      chk(cyc == 64 * 2, "R8", "read busy cycles", cyc, 64 * 2);
      chk(data_rdata == 16'h8001, "R6", "read data", data_rdata, 16'h8001);

      // R7 read without preamble, divider 2
      phy_val = 16'h3C5A;
      run_cmd(mk(2, 1, 1, 0, 5'h03, 5'h10), 0, '0, cyc);
      chk(cyc == 32 * 6, "R7", "short read busy cycles", cyc, 32 * 6);
      chk(data_rdata == 16'h3C5A, "R6", "short read data", data_rdata, 16'h3C5A);

      // R9 write without preamble, divider 0xA, command written mid-frame
      put_data(16'hFFFF);
      w = mk(10, 1, 1, 1, 5'h01, 5'h00);
      run_cmd(w, 1, mk(3, 0, 1, 0, 5'h0E, 5'h1B), cyc);
      chk(cyc == 32 * 22, "R9", "busy cycles with ignored write", cyc, 32 * 22);
      chk(cmd_rdata == (w & ~32'h0002_0000), "R9", "fields after ignored write",
          cmd_rdata, w & ~32'h0002_0000);

      // R2 command without start bit: stored, no frame
      w = mk(3, 0, 0, 0, 5'h02, 5'h03);
      cmd_wr = 1'b1; cmd_wdata = w;
      @(negedge clk);
      cmd_wr = 1'b0;
      for (int i = 0; i < 20; i++) begin
         chk(cmd_rdata[17] == 1'b0, "R2", "busy after write without start", cmd_rdata[17], 0);
         chk(mdc == 1'b0, "R3", "mdc idle", mdc, 0);
         @(negedge clk);
      end
      chk(cmd_rdata == w, "R2", "stored fields without start", cmd_rdata, w);

      // typical divider read with preamble
      phy_val = 16'h1234;
      run_cmd(mk(10, 0, 1, 0, 5'h01, 5'h01), 0, '0, cyc);
      chk(cyc == 64 * 22, "R8", "default divider busy cycles", cyc, 64 * 22);
      chk(data_rdata == 16'h1234, "R6", "default divider read data", data_rdata, 16'h1234);
      chk(mdio_oe == 1'b0, "R8", "mdio_oe idle after frame", mdio_oe, 0);

      repeat (5) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule